// File: doc/BRIEF.md
# Four-Column Interleaved Parity Generator and Checker

This block protects the payload of a framed nibble stream with a four-column, bit-interleaved, even parity. Column k is the XOR of bit k of every payload nibble in one frame. Bit 3 of a nibble is the first bit on the line and bit 0 the last, so bit k of the parity nibble always covers bit k of the data. Framing and service slots are marked as not valid and stay out of the sum. The parity itself travels in a dedicated slot at the end of each frame.

The transmit path passes its nibble stream through one register. In the parity slot it puts the parity of the frame in place of the input nibble. The receive path computes the same sum over the incoming frame and compares it, column by column, with the nibble found in that frame's parity slot. It then raises a one-cycle pulse on each column that differs and a one-cycle summary pulse. A saturating counter adds up the failed columns. A single enable switches the whole function. Frame alignment comes from outside, as a frame-start marker and a parity-slot marker on each side.

Top module: `bip4_gen_chk`

## Requirements
- R1: While reset is held, and on the first cycle after it, `tx_out`, `rx_col_err`, `rx_err` and `rx_err_cnt` are all zero.
- R2: On transmit, a nibble presented with `tx_pslot` low appears unchanged on `tx_out` one clock later. This holds whatever the state of `tx_dv` and `tx_sof`.
- R3: On transmit with `bip_en` high, the nibble presented with `tx_pslot` high is replaced one clock later on `tx_out`. The replacement is the even parity: bit k equals the XOR of bit k of every nibble presented with `tx_dv` high and `tx_pslot` low, counted from the last `tx_sof` cycle (that cycle included).
- R4: A nibble presented with `tx_dv` low is left out of the parity on both paths.
- R5: A frame-start marker discards the sum of the previous frame, so each parity covers only its own frame. A parity slot on a `*_sof` cycle carries zero.
- R6: With `bip_en` low, the transmit parity slot passes its input nibble unchanged. No receive error is flagged, and `rx_err_cnt` holds its value.
- R7: On receive with `bip_en` high, one clock after the `rx_pslot` cycle, bit k of `rx_col_err` is high exactly when bit k of the received nibble differs from bit k of the computed parity.
- R8: `rx_err` is high on exactly the cycles where `rx_col_err` is nonzero.
- R9: `rx_err_cnt` grows by the number of set bits of `rx_col_err`, updated on the same clock edge as `rx_col_err`.
- R10: `rx_err_cnt` saturates at 2^CNT_W-1 (255 by default) and never wraps.
- R11: `rx_col_err` and `rx_err` are zero on every cycle except the one that follows an enabled receive parity slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bip_en | input | 1 | Enables parity insertion and checking |
| tx_sof | input | 1 | Transmit frame-start marker |
| tx_dv | input | 1 | Transmit nibble is payload |
| tx_pslot | input | 1 | Transmit nibble is the parity slot |
| tx_nib | input | 4 | Transmit nibble in, bit 3 first on line |
| tx_out | output | 4 | Transmit nibble out, one clock later |
| rx_sof | input | 1 | Receive frame-start marker |
| rx_dv | input | 1 | Receive nibble is payload |
| rx_pslot | input | 1 | Receive nibble is the parity slot |
| rx_nib | input | 4 | Receive nibble, bit 3 first on line |
| rx_col_err | output | 4 | Per-column mismatch pulse |
| rx_err | output | 1 | Any-column mismatch pulse |
| rx_err_cnt | output | CNT_W | Saturating count of failed columns |

## Verification
The bench inserts idle and service slots inside frames. A design that summed them would send a wrong parity. It also sends frames back to back with different data, which catches an accumulator that is not cleared at frame start. Single-column and all-column mismatches check the mapping of columns to bits and the per-column weight of the counter. A design that counted once per frame, or swapped bit order, would show a wrong `rx_col_err` or count. A long run of four-column errors drives the counter past its ceiling, where a wrapping counter would fall back to small values. Frames sent with the enable low must leave the parity slot alone and produce no error pulse.

// File: rtl/bip4_pkg.sv
package bip4_pkg;

    localparam int BIP_COLS = 4;

    typedef logic [BIP_COLS-1:0] col_vec_t;

    function automatic int col_popcount(input col_vec_t v);
        int n;
        n = 0;
        for (int i = 0; i < BIP_COLS; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/bip_col_acc.sv
module bip_col_acc
    import bip4_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sof,
    input  logic     dv,
    input  logic     pslot,
    input  col_vec_t nib,
    output col_vec_t run
);
    typedef struct packed {
        col_vec_t acc;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        // running sum seen by the current slot, cleared at frame start
        run = sof ? '0 : st_q.acc;
        st_d = st_q;
        if (pslot) begin
            st_d.acc = run;
        end else if (dv) begin
            st_d.acc = run ^ nib;
        end else begin
            st_d.acc = run;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bip_tx_ins.sv
module bip_tx_ins
    import bip4_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     pslot,
    input  col_vec_t nib,
    input  col_vec_t par,
    output col_vec_t out_nib
);
    typedef struct packed {
        col_vec_t nib;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.nib = (en && pslot) ? par : nib;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_nib = st_q.nib;
endmodule

// File: rtl/bip_rx_chk.sv
module bip_rx_chk
    import bip4_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pslot,
    input  col_vec_t         nib,
    input  col_vec_t         par,
    output col_vec_t         col_err,
    output logic             err,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    typedef struct packed {
        col_vec_t         col_err;
        logic             err;
        logic [CNT_W-1:0] cnt;
    } rx_st_t;

    rx_st_t         st_d, st_q;
    col_vec_t       mism;
    logic [CNT_W:0] sum;

    always_comb begin
        st_d = st_q;
        mism = (en && pslot) ? (par ^ nib) : '0;
        sum  = {1'b0, st_q.cnt} + (CNT_W+1)'(col_popcount(mism));
        st_d.col_err = mism;
        st_d.err     = (mism != '0);
        st_d.cnt     = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_err = st_q.col_err;
    assign err     = st_q.err;
    assign cnt     = st_q.cnt;
endmodule

// File: rtl/bip4_gen_chk.sv
module bip4_gen_chk
    import bip4_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bip_en,
    input  logic             tx_sof,
    input  logic             tx_dv,
    input  logic             tx_pslot,
    input  logic [3:0]       tx_nib,
    output logic [3:0]       tx_out,
    input  logic             rx_sof,
    input  logic             rx_dv,
    input  logic             rx_pslot,
    input  logic [3:0]       rx_nib,
    output logic [3:0]       rx_col_err,
    output logic             rx_err,
    output logic [CNT_W-1:0] rx_err_cnt
);
    col_vec_t tx_run, rx_run;

    bip_col_acc u_tx_acc (
        .clk(clk), .rst_n(rst_n), .sof(tx_sof), .dv(tx_dv),
        .pslot(tx_pslot), .nib(tx_nib), .run(tx_run)
    );

    bip_tx_ins u_tx_ins (
        .clk(clk), .rst_n(rst_n), .en(bip_en), .pslot(tx_pslot),
        .nib(tx_nib), .par(tx_run), .out_nib(tx_out)
    );

    bip_col_acc u_rx_acc (
        .clk(clk), .rst_n(rst_n), .sof(rx_sof), .dv(rx_dv),
        .pslot(rx_pslot), .nib(rx_nib), .run(rx_run)
    );

    bip_rx_chk #(.CNT_W(CNT_W)) u_rx_chk (
        .clk(clk), .rst_n(rst_n), .en(bip_en), .pslot(rx_pslot),
        .nib(rx_nib), .par(rx_run), .col_err(rx_col_err),
        .err(rx_err), .cnt(rx_err_cnt)
    );
endmodule

// File: rtl/bip4_gen_chk_sva.sv
module bip4_gen_chk_sva #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bip_en,
    input logic             tx_pslot,
    input logic [3:0]       tx_nib,
    input logic [3:0]       tx_out,
    input logic             rx_pslot,
    input logic [3:0]       rx_col_err,
    input logic             rx_err,
    input logic [CNT_W-1:0] rx_err_cnt
);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic             seen_q;
    logic [CNT_W-1:0] cnt_prev_q;
    logic [CNT_W:0]   want_raw;
    logic [CNT_W-1:0] want;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            cnt_prev_q <= '0;
        end else begin
            seen_q     <= 1'b1;
            cnt_prev_q <= rx_err_cnt;
        end
    end

    always_comb begin
        want_raw = {1'b0, cnt_prev_q} + (CNT_W+1)'($countones(rx_col_err));
        want     = (want_raw > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : want_raw[CNT_W-1:0];
    end

    AST_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(tx_pslot)) |-> (tx_out == $past(tx_nib))); // R2

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err == (rx_col_err != 4'd0)); // R8

    AST_ERR_ONLY_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (rx_col_err != 4'd0)) |-> $past(rx_pslot && bip_en)); // R11

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (rx_err_cnt == want)); // R9

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (rx_err_cnt >= cnt_prev_q)); // R10

    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(bip_en)) |-> ((rx_col_err == 4'd0) && $stable(rx_err_cnt))); // R6
endmodule

bind bip4_gen_chk bip4_gen_chk_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .bip_en(bip_en), .tx_pslot(tx_pslot),
    .tx_nib(tx_nib), .tx_out(tx_out), .rx_pslot(rx_pslot),
    .rx_col_err(rx_col_err), .rx_err(rx_err), .rx_err_cnt(rx_err_cnt)
);

// File: tb/sim_bip4_gen_chk.sv
module sim_bip4_gen_chk;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bip_en = 1'b0;
    logic             tx_sof = 1'b0, tx_dv = 1'b0, tx_pslot = 1'b0;
    logic [3:0]       tx_nib = 4'd0;
    logic [3:0]       tx_out;
    logic             rx_sof = 1'b0, rx_dv = 1'b0, rx_pslot = 1'b0;
    logic [3:0]       rx_nib = 4'd0;
    logic [3:0]       rx_col_err;
    logic             rx_err;
    logic [CNT_W-1:0] rx_err_cnt;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bip4_gen_chk #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bip_en(bip_en),
        .tx_sof(tx_sof), .tx_dv(tx_dv), .tx_pslot(tx_pslot), .tx_nib(tx_nib),
        .tx_out(tx_out),
        .rx_sof(rx_sof), .rx_dv(rx_dv), .rx_pslot(rx_pslot), .rx_nib(rx_nib),
        .rx_col_err(rx_col_err), .rx_err(rx_err), .rx_err_cnt(rx_err_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one tx slot at a negedge, return at the next negedge
    task automatic tx_slot(input logic s, input logic d, input logic p, input logic [3:0] n);
        tx_sof = s; tx_dv = d; tx_pslot = p; tx_nib = n;
        @(negedge clk);
        tx_sof = 0; tx_dv = 0; tx_pslot = 0;
    endtask

    task automatic rx_slot(input logic s, input logic d, input logic p, input logic [3:0] n);
        rx_sof = s; rx_dv = d; rx_pslot = p; rx_nib = n;
        @(negedge clk);
        rx_sof = 0; rx_dv = 0; rx_pslot = 0;
    endtask

    // frame: framing slot, six slots of data (dvm selects payload), parity slot
    task automatic tx_frame(input logic [23:0] d, input logic [5:0] dvm,
                            input logic en, input string tag);
        logic [3:0] par = 4'd0;
        bip_en = en;
        tx_slot(1'b1, 1'b0, 1'b0, 4'hF);
        check({"R2 framing slot ", tag}, tx_out, 4'hF);
        for (int i = 0; i < 6; i++) begin
            logic [3:0] nb = d[23-4*i -: 4];
            if (dvm[5-i]) par ^= nb;
            tx_slot(1'b0, dvm[5-i], 1'b0, nb);
            check({"R2 data pass ", tag}, tx_out, nb);
        end
        tx_slot(1'b0, 1'b0, 1'b1, 4'hA);
        if (en) check({"R3 R4 R5 parity ", tag}, tx_out, par);
        else    check({"R6 parity slot untouched ", tag}, tx_out, 4'hA);
    endtask

    task automatic rx_frame(input logic [23:0] d, input logic [5:0] dvm, input logic [3:0] flip,
                            input logic en, input logic quiet, input string tag);
        logic [3:0] par = 4'd0;
        logic [3:0] ex;
        bip_en = en;
        rx_slot(1'b1, 1'b0, 1'b0, 4'h5);
        for (int i = 0; i < 6; i++) begin
            logic [3:0] nb = d[23-4*i -: 4];
            if (dvm[5-i]) par ^= nb;
            rx_slot(1'b0, dvm[5-i], 1'b0, nb);
            if (!quiet) check({"R11 no error mid-frame ", tag}, rx_err, 0);
        end
        rx_slot(1'b0, 1'b0, 1'b1, par ^ flip);
        ex = en ? flip : 4'd0;
        exp_cnt = exp_cnt + $countones(ex);
        if (exp_cnt > 255) exp_cnt = 255;
        if (!quiet) begin
            check({"R7 R6 column error ", tag}, rx_col_err, ex);
            check({"R8 summary error ", tag}, rx_err, (ex != 0) ? 1 : 0);
            check({"R9 R6 count ", tag}, rx_err_cnt, exp_cnt);
        end
        rx_slot(1'b0, 1'b0, 1'b0, 4'd0);
        if (!quiet) check({"R11 pulse one cycle ", tag}, rx_col_err, 0);
    endtask

    task automatic test_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 tx_out in reset", tx_out, 0);
        check("R1 col_err in reset", rx_col_err, 0);
        check("R1 cnt in reset", rx_err_cnt, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 err after reset", rx_err, 0);
        check("R1 cnt after reset", rx_err_cnt, 0);
    endtask

    task automatic test_tx();
        tx_frame(24'h123456, 6'b111111, 1'b1, "full");
        tx_frame(24'hF0F0F7, 6'b101101, 1'b1, "gaps");
        tx_frame(24'h000008, 6'b000001, 1'b1, "fresh frame");
        tx_frame(24'h9ABCDE, 6'b111111, 1'b0, "disabled");
        // parity slot on a frame-start cycle carries zero
        bip_en = 1;
        tx_slot(1'b0, 1'b1, 1'b0, 4'h7);
        tx_slot(1'b1, 1'b0, 1'b1, 4'hC);
        check("R5 parity on sof cycle", tx_out, 0);
    endtask

    task automatic test_rx();
        rx_frame(24'h13579B, 6'b111111, 4'h0, 1'b1, 1'b0, "match");
        rx_frame(24'h2468AC, 6'b110011, 4'h8, 1'b1, 1'b0, "col3");
        rx_frame(24'hFEDCBA, 6'b111111, 4'h1, 1'b1, 1'b0, "col0");
        rx_frame(24'h111111, 6'b101010, 4'hF, 1'b1, 1'b0, "all cols");
        rx_frame(24'h777777, 6'b111111, 4'hF, 1'b0, 1'b0, "disabled");
        check("R6 count held while disabled", rx_err_cnt, exp_cnt);
    endtask

    task automatic test_sat();
        for (int k = 0; k < 66; k++) begin
            rx_frame(24'h0A0B0C, 6'b111111, 4'hF, 1'b1, 1'b1, "sat");
        end
        check("R10 count saturated", rx_err_cnt, 255);
        rx_frame(24'h0A0B0C, 6'b111111, 4'h3, 1'b1, 1'b0, "after sat");
        check("R10 stays at ceiling", rx_err_cnt, 255);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_tx();
        test_rx();
        test_sat();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule